// File: doc/BRIEF.md
# Interleaved Banked Scratch Memory

This block is the shared on-chip scratch store of one compute unit. It holds 32-bit words spread over several banks, each with a single read/write port of its own. Two wavefronts issue vector requests to it. A request carries a word address for every lane, a lane enable mask, and either store data per lane or a load intent. The block maps each enabled lane to a bank by the low bits of its word address. It then works through the lanes, one access per bank per cycle, until every enabled lane has been handled.

When both wavefronts offer a request at once, a round-robin arbiter picks one, and only one request is in flight at a time. Lanes that land in different banks are served in the same cycle. Lanes that land in one bank at different words are served one after another in ascending lane order. Lanes that name the very same word share a single access. When the last round has finished and its read data has been collected, the block pulses a completion bit for the wavefront that owned the request. It presents the per-lane load data on a shared response bus in that same cycle.

Top module: `lmem_banked_top`

## Requirements
- R1: After reset, with no request offered, every bit of `req_ready` and `rsp_done` is 0.
- R2: A lane's bank is its word address modulo BANKS (low 5 bits by default) and its row is the address divided by BANKS. A full-mask request whose 32 lanes address 32 consecutive words finishes in one round, so `rsp_done` is seen 3 cycles after the accepting clock edge.
- R3: Enabled lanes that hit one bank at distinct words are served in ascending lane order, one per cycle. `rsp_done` is seen K+2 cycles after acceptance, where K is the largest number of distinct words any single bank must supply (K is at least 1, also for an empty mask).
- R4: Enabled lanes that address the same word are served together in one access, so a request where every lane loads one word completes with K = 1 and all lanes return that word.
- R5: A store leaves the words named by masked-off lanes unchanged.
- R6: While `rsp_done` is high, `rsp_rdata[32*i +: 32]` holds lane i's load result. Lanes that were masked off read as zero.
- R7: When several enabled lanes of one store name the same word, the value of the lowest-numbered such lane is written.
- R8: When both wavefronts request, grants alternate between them. The first contested grant after reset goes to wavefront 0.
- R9: `req_ready` is raised only while no request is in flight, for at most one wavefront. `rsp_done` is a one-cycle pulse on the bit of the wavefront that issued the request.
- R10: A load returns for each enabled lane the word last stored at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NUM_WAVES | Request offered, one bit per wavefront |
| req_ready | output | NUM_WAVES | Request accepted at this clock edge when valid is also high |
| req_write | input | NUM_WAVES | 1 = store, 0 = load, per wavefront |
| req_mask | input | NUM_WAVES*LANES | Lane enables; wavefront w at [w*LANES +: LANES] |
| req_addr | input | NUM_WAVES*LANES*ADDR_W | Word address per lane; lane i of wavefront w at [(w*LANES+i)*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_WAVES*LANES*DATA_W | Store data per lane, laid out like the addresses |
| rsp_done | output | NUM_WAVES | One-cycle completion pulse for the owning wavefront |
| rsp_rdata | output | LANES*DATA_W | Per-lane load data, valid while rsp_done is high |

## Verification
Results are due a fixed number of cycles after the accepting edge. There are K service rounds, one cycle to capture the last bank read, and one cycle with the completion pulse, so the pulse is seen K+2 cycles after acceptance. The bench computes K itself from the lane addresses and mask, counting distinct words per bank. It samples every output on the falling edge and counts falling edges from the accepting edge, so it compares the measured latency with K+2 exactly. Load data is read in the same pulse cycle and compared with a word-level model that applies the lowest-lane-wins rule for duplicate store addresses.

// File: rtl/lmem_pkg.sv
`timescale 1ns/1ps
package lmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } lm_state_e;
endpackage

// File: rtl/lmem_rr_arb.sv
`timescale 1ns/1ps
module lmem_rr_arb #(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] last_q;
  logic             found;
  int               cand;

  always_comb begin
    gnt     = '0;
    gnt_idx = last_q;
    found   = 1'b0;
    cand    = 0;
    for (int k = 1; k <= int'(N); k++) begin
      cand = int'(last_q) + k;
      if (cand >= int'(N)) cand = cand - int'(N);
      if (!found && req[cand]) begin
        found     = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IDX_W'(N - 1);
    end else if (advance) begin
      last_q <= gnt_idx;
    end
  end

  AST_RR_SKIP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~(N'(1) << last_q)) != '0) |-> !gnt[last_q]); // R8
endmodule

// File: rtl/lmem_lane_sched.sv
`timescale 1ns/1ps
module lmem_lane_sched #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned BANKS  = 32,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES*DATA_W-1:0] wdata,
  output logic [BANKS-1:0]        bank_en,
  output logic [BANKS*IDX_W-1:0]  bank_idx,
  output logic [BANKS*DATA_W-1:0] bank_wdata,
  output logic [LANES-1:0]        served
);
  localparam int unsigned BANK_W = $clog2(BANKS);

  logic [BANKS*ADDR_W-1:0] bank_addr;

  // Per bank: the lowest pending lane mapped to it owns this round.
  for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
    logic              hit;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;
    always_comb begin
      hit      = 1'b0;
      sel_addr = '0;
      sel_data = '0;
      for (int l = int'(LANES) - 1; l >= 0; l--) begin
        if (pend[l] && (addr[l*ADDR_W +: BANK_W] == BANK_W'(b))) begin
          hit      = 1'b1;
          sel_addr = addr[l*ADDR_W +: ADDR_W];
          sel_data = wdata[l*DATA_W +: DATA_W];
        end
      end
    end
    assign bank_en[b]                       = hit;
    assign bank_addr[b*ADDR_W +: ADDR_W]    = sel_addr;
    assign bank_idx[b*IDX_W +: IDX_W]       = sel_addr[ADDR_W-1:BANK_W];
    assign bank_wdata[b*DATA_W +: DATA_W]   = sel_data;
  end

  // A lane rides along with its bank's access when it names the same word.
  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    assign served[l] = pend[l] &&
      (addr[l*ADDR_W +: ADDR_W] ==
       bank_addr[int'(addr[l*ADDR_W +: BANK_W])*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/lmem_bank.sv
`timescale 1ns/1ps
module lmem_bank #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (en && !we) begin
      rdata <= mem[idx];
    end
  end
endmodule

// File: rtl/lmem_banked_top.sv
`timescale 1ns/1ps
module lmem_banked_top #(
  parameter int unsigned NUM_WAVES      = 2,
  parameter int unsigned LANES          = 32,
  parameter int unsigned BANKS          = 32,
  parameter int unsigned WORDS_PER_BANK = 64,
  parameter int unsigned DATA_W         = 32,
  localparam int unsigned ADDR_W        = $clog2(BANKS * WORDS_PER_BANK)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_WAVES-1:0]                req_valid,
  output logic [NUM_WAVES-1:0]                req_ready,
  input  logic [NUM_WAVES-1:0]                req_write,
  input  logic [NUM_WAVES*LANES-1:0]          req_mask,
  input  logic [NUM_WAVES*LANES*ADDR_W-1:0]   req_addr,
  input  logic [NUM_WAVES*LANES*DATA_W-1:0]   req_wdata,
  output logic [NUM_WAVES-1:0]                rsp_done,
  output logic [LANES*DATA_W-1:0]             rsp_rdata
);
  import lmem_pkg::*;

  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned IDX_W  = ADDR_W - BANK_W;
  localparam int unsigned WID_W  = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  lm_state_e               state_q, state_d;
  logic [WID_W-1:0]        wave_q, wave_d;
  logic                    we_q, we_d;
  logic [LANES-1:0]        pend_q, pend_d, srv_q, srv_d;
  logic [LANES*ADDR_W-1:0] addr_q, addr_d;
  logic [LANES*DATA_W-1:0] wdat_q, wdat_d, lane_q, lane_d;

  logic [NUM_WAVES-1:0]    gnt;
  logic [WID_W-1:0]        gnt_idx;
  logic                    accept;

  logic [BANKS-1:0]        sch_en, bank_en;
  logic [BANKS*IDX_W-1:0]  bank_idx;
  logic [BANKS*DATA_W-1:0] bank_wdata, bank_rd;
  logic [LANES-1:0]        served;

  assign accept = (state_q == ST_IDLE) && ((req_valid & gnt) != '0);

  lmem_rr_arb #(.N(NUM_WAVES), .IDX_W(WID_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_ni),
    .req     (req_valid),
    .advance (accept),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  lmem_lane_sched #(
    .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_sched (
    .pend       (pend_q),
    .addr       (addr_q),
    .wdata      (wdat_q),
    .bank_en    (sch_en),
    .bank_idx   (bank_idx),
    .bank_wdata (bank_wdata),
    .served     (served)
  );

  assign bank_en = sch_en & {BANKS{state_q == ST_SERVE}};

  for (genvar b = 0; b < int'(BANKS); b++) begin : g_mem
    lmem_bank #(.DEPTH(WORDS_PER_BANK), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_ni),
      .en    (bank_en[b]),
      .we    (we_q),
      .idx   (bank_idx[b*IDX_W +: IDX_W]),
      .wdata (bank_wdata[b*DATA_W +: DATA_W]),
      .rdata (bank_rd[b*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    state_d = state_q;
    wave_d  = wave_q;
    we_d    = we_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    lane_d  = lane_q;
    srv_d   = (state_q == ST_SERVE && !we_q) ? served : '0;
    // Collect bank read data one cycle after the lane was served.
    for (int l = 0; l < int'(LANES); l++) begin
      if (srv_q[l]) begin
        lane_d[l*DATA_W +: DATA_W] =
          bank_rd[int'(addr_q[l*ADDR_W +: BANK_W])*DATA_W +: DATA_W];
      end
    end
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SERVE;
          wave_d  = gnt_idx;
          we_d    = req_write[gnt_idx];
          pend_d  = req_mask[int'(gnt_idx)*LANES +: LANES];
          addr_d  = req_addr[int'(gnt_idx)*LANES*ADDR_W +: LANES*ADDR_W];
          wdat_d  = req_wdata[int'(gnt_idx)*LANES*DATA_W +: LANES*DATA_W];
          lane_d  = '0;
        end
      end
      ST_SERVE: begin
        pend_d = pend_q & ~served;
        if (pend_d == '0) state_d = ST_FLUSH;
      end
      ST_FLUSH: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wave_q  <= '0;
      we_q    <= 1'b0;
      pend_q  <= '0;
      srv_q   <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      srv_q   <= srv_d;
      lane_q  <= lane_d;
      if (accept) begin
        wave_q <= wave_d;
        we_q   <= we_d;
        addr_q <= addr_d;
        wdat_q <= wdat_d;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE) ? gnt : '0;
  assign rsp_rdata = lane_q;
  for (genvar w = 0; w < int'(NUM_WAVES); w++) begin : g_done
    assign rsp_done[w] = (state_q == ST_DONE) && (wave_q == WID_W'(w));
  end

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(req_ready)); // R9
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(rsp_done)); // R9
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> (req_ready == '0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_done != '0) |=> (rsp_done == '0)); // R9
  AST_SERVE_PROGRESS: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SERVE && pend_q != '0) |=>
      ($countones(pend_q) < $past($countones(pend_q)))); // R3
  AST_NO_BANK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_SERVE) |-> (bank_en == '0)); // R5
endmodule

// File: tb/lmem_banked_top_tb.sv
`timescale 1ns/1ps
module lmem_banked_top_tb;
  localparam int W  = 2;
  localparam int L  = 32;
  localparam int B  = 32;
  localparam int D  = 64;
  localparam int DW = 32;
  localparam int AW = 11;

  logic              clk;
  logic              rst_n;
  logic [W-1:0]      req_valid;
  logic [W-1:0]      req_ready;
  logic [W-1:0]      req_write;
  logic [W*L-1:0]    req_mask;
  logic [W*L*AW-1:0] req_addr;
  logic [W*L*DW-1:0] req_wdata;
  logic [W-1:0]      rsp_done;
  logic [L*DW-1:0]   rsp_rdata;

  lmem_banked_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mask(req_mask), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int          n_chk;
  int          n_bad;
  int          lat;
  logic [AW-1:0] t_addr [L];
  logic [31:0]   t_data [L];
  logic [31:0]   r_data [L];
  logic [31:0]   mdl [B*D];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic int rounds(input logic [31:0] m);
    int cnt [B];
    int mx;
    bit uniq;
    mx = 0;
    for (int b = 0; b < B; b++) cnt[b] = 0;
    for (int l = 0; l < L; l++) begin
      if (m[l]) begin
        uniq = 1'b1;
        for (int j = 0; j < l; j++)
          if (m[j] && t_addr[j] == t_addr[l]) uniq = 1'b0;
        if (uniq) cnt[int'(t_addr[l]) % B]++;
      end
    end
    for (int b = 0; b < B; b++) if (cnt[b] > mx) mx = cnt[b];
    if (mx == 0) mx = 1;
    return mx;
  endfunction

  task automatic op(input int w, input bit wr, input logic [31:0] m, input string tag);
    int k;
    k = rounds(m);
    @(negedge clk);
    req_write[w] = wr;
    req_mask[w*L +: L] = m;
    for (int l = 0; l < L; l++) begin
      req_addr[(w*L+l)*AW +: AW]  = t_addr[l];
      req_wdata[(w*L+l)*DW +: DW] = t_data[l];
    end
    req_valid[w] = 1'b1;
    while (req_ready[w] !== 1'b1) @(negedge clk);
    @(negedge clk);
    req_valid[w] = 1'b0;
    lat = 1;
    chk("R9 ready while busy", 32'(req_ready), 32'd0);
    while (rsp_done[w] !== 1'b1) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " latency"}, 32'(lat), 32'(k + 2));
    chk("R9 done owner", 32'(rsp_done), 32'(1 << w));
    for (int l = 0; l < L; l++) r_data[l] = rsp_rdata[l*DW +: DW];
    if (wr) begin
      for (int l = L - 1; l >= 0; l--)
        if (m[l]) mdl[t_addr[l]] = t_data[l];
    end
    @(negedge clk);
    chk("R9 done pulse", 32'(rsp_done), 32'd0);
  endtask

  task automatic exp_load(input logic [31:0] m, input string tag);
    for (int l = 0; l < L; l++)
      chk(tag, r_data[l], m[l] ? mdl[t_addr[l]] : 32'd0);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd0);
    chk("R1 done after reset", 32'(rsp_done), 32'd0);
  endtask

  task automatic t_stride;
    for (int l = 0; l < L; l++) begin
      t_addr[l] = AW'(l);
      t_data[l] = 32'hA000_0000 + 32'(l);
    end
    op(0, 1'b1, 32'hFFFF_FFFF, "R2 store");
    op(0, 1'b0, 32'hFFFF_FFFF, "R2 load");
    exp_load(32'hFFFF_FFFF, "R10 stride data");
  endtask

  task automatic t_conflict;
    for (int l = 0; l < L; l++) begin
      t_addr[l] = AW'(l * B + 1);
      t_data[l] = 32'hC0DE_0000 + 32'(l * 7);
    end
    op(1, 1'b1, 32'hFFFF_FFFF, "R3 store");
    op(1, 1'b0, 32'hFFFF_FFFF, "R3 load");
    exp_load(32'hFFFF_FFFF, "R3 conflict data");
    for (int l = 0; l < L; l++) t_addr[l] = AW'(((l % 4) * B) + 1);
    op(0, 1'b0, 32'h0000_00FF, "R3 partial");
    exp_load(32'h0000_00FF, "R3 partial data");
  endtask

  task automatic t_broadcast;
    for (int l = 0; l < L; l++) t_addr[l] = AW'(5);
    op(0, 1'b0, 32'hFFFF_FFFF, "R4 load");
    for (int l = 0; l < L; l++) chk("R4 broadcast data", r_data[l], 32'hA000_0005);
  endtask

  task automatic t_mask;
    for (int l = 0; l < L; l++) begin
      t_addr[l] = AW'(l);
      t_data[l] = 32'h5A5A_0000 + 32'(l);
    end
    op(1, 1'b1, 32'h0000_FFFF, "R5 store");
    op(1, 1'b0, 32'hFFFF_FFFF, "R5 load");
    for (int l = 16; l < L; l++) chk("R5 untouched word", r_data[l], 32'hA000_0000 + 32'(l));
    exp_load(32'hFFFF_FFFF, "R5 data");
    op(0, 1'b0, 32'hF0F0_F0F0, "R6 load");
    exp_load(32'hF0F0_F0F0, "R6 masked lanes zero");
    op(0, 1'b0, 32'h0000_0000, "R6 empty");
    exp_load(32'h0000_0000, "R6 empty data");
  endtask

  task automatic t_dup;
    for (int l = 0; l < L; l++) begin
      t_addr[l] = AW'(200 + l);
      t_data[l] = 32'hD00D_0000 + 32'(l);
    end
    t_addr[3]  = AW'(100);
    t_addr[7]  = AW'(100);
    t_addr[20] = AW'(100);
    op(0, 1'b1, 32'hFFFF_FFFF, "R7 store");
    for (int l = 0; l < L; l++) t_addr[l] = AW'(100);
    op(1, 1'b0, 32'h0000_0001, "R7 load");
    chk("R7 lowest lane wins", r_data[0], 32'hD00D_0003);
  endtask

  task automatic t_rr;
    int order [4];
    int n;
    int left [W];
    bit drop [W];
    logic [31:0] seen5 [4];
    n = 0;
    @(negedge clk);
    for (int w = 0; w < W; w++) begin
      left[w] = 2;
      drop[w] = 1'b0;
      req_write[w] = 1'b0;
      req_mask[w*L +: L] = 32'hFFFF_FFFF;
      for (int l = 0; l < L; l++)
        req_addr[(w*L+l)*AW +: AW] = (w == 0) ? AW'(l) : AW'(l * B + 1);
    end
    req_valid = 2'b11;
    while (n < 4) begin
      @(negedge clk);
      for (int w = 0; w < W; w++) begin
        if (drop[w]) begin
          req_valid[w] = 1'b0;
          drop[w] = 1'b0;
        end
        if (rsp_done[w] === 1'b1) begin
          order[n] = w;
          seen5[n] = rsp_rdata[5*DW +: DW];
          n++;
        end
        if (req_ready[w] === 1'b1 && req_valid[w]) begin
          left[w]--;
          if (left[w] == 0) drop[w] = 1'b1;
        end
      end
    end
    for (int i = 0; i < 4; i++) begin
      chk("R8 grant order", 32'(order[i]), 32'(i % 2));
      chk("R10 rr data", seen5[i], (i % 2 == 0) ? mdl[5] : mdl[5 * B + 1]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req_valid = '0;
    req_write = '0;
    req_mask  = '0;
    req_addr  = '0;
    req_wdata = '0;
    for (int i = 0; i < B * D; i++) mdl[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stride();
    t_conflict();
    t_broadcast();
    t_mask();
    t_dup();
    t_rr();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule